// File: doc/BRIEF.md
# DC Offset Removal Filter

This block strips a slowly varying DC component from a stream of 16-bit two's-complement samples. In its tracking modes it keeps a running estimate of the offset with a first-order leaky integrator, and it subtracts the integer part of that estimate from each sample. Three tracking bandwidths are available. A fourth mode ignores the estimate and subtracts a fixed offset that the host has loaded. Every result is saturated to the signed 16-bit range.

A single 32-bit control word is written through a write strobe and resets to zero. Bit 18 disables the filter, which also clears the estimate. Bits 17:16 choose the mode. Bits 15:0 hold the fixed offset. Samples arrive with a valid flag, and each result appears one cycle later with its own valid flag.

Top module: `dc_trim`

## Requirements
- R1: After synchronous reset, out_valid and out_sample are 0, the control word is all zeros (tracking, widest bandwidth, enabled) and the offset estimate is 0, so the first sample after reset passes through unchanged.
- R2: Each cycle with in_valid high produces exactly one result with out_valid high on the next cycle. out_valid is low in every other cycle.
- R3: With mode field bits 17:16 = 00 and bit 18 = 0, each valid sample x gives out = x − floor(E/2^16), using the estimate E from before that sample. E then updates as E += (x·2^16 − E) >>> 8 (arithmetic shift), so E carries 16 fractional bits.
- R4: Mode field 01 behaves as R3 with a shift of 12.
- R5: Mode field 10 behaves as R3 with a shift of 16.
- R6: Mode field 11 subtracts the two's-complement offset in bits 15:0, weighted like the sample, and leaves the estimate unchanged, so tracking resumes from the held value when the mode returns to 00, 01 or 10.
- R7: While bit 18 is 1, the estimate is forced to 0 and is not updated. When the mode is not 11, samples pass through unchanged, and the first tracking sample after re-enabling sees an estimate of 0.
- R8: While bit 18 is 1 and the mode is 11, the host offset is still subtracted.
- R9: A difference above 32767 gives 32767, and a difference below −32768 gives −32768.
- R10: Bits 31:19 of the control word have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: bit 18 disable, bits 17:16 mode, bits 15:0 host offset |
| in_valid | input | 1 | Input sample valid |
| in_sample | input | 16 | Input sample, two's complement |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_sample | output | 16 | Offset-corrected, saturated result |

## Verification
A control word written with cfg_we is in force for samples presented from the next cycle on. A sample presented in a cycle has its result on the ports in the following cycle. The bench computes each expected result when it drives the sample, using its own model of the estimate, and queues that result. A monitor samples the ports on the falling edge after each rising edge, pops one queued item for every out_valid, and reports any out_valid that has no item waiting, so a late, early or extra result counts as a mismatch.

// File: rtl/dc_trim_pkg.sv
package dc_trim_pkg;

    localparam int SAMPLE_W = 16;
    localparam int FRAC_W   = 16;
    localparam int CFG_W    = 32;
    localparam int DIS_BIT  = 18;
    localparam int MODE_LSB = 16;

    typedef enum logic [1:0] {
        TRACK_WIDE   = 2'b00,
        TRACK_MED    = 2'b01,
        TRACK_NARROW = 2'b10,
        HOST_FIXED   = 2'b11
    } trim_mode_e;

    typedef struct packed {
        logic                       dis;
        trim_mode_e                 mode;
        logic signed [SAMPLE_W-1:0] ofs;
    } trim_cfg_t;

    function automatic trim_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
        trim_cfg_t c;
        c.dis  = w[DIS_BIT];
        c.mode = trim_mode_e'(w[MODE_LSB+1:MODE_LSB]);
        c.ofs  = w[SAMPLE_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/dc_trim_cfg.sv
module dc_trim_cfg
    import dc_trim_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output trim_cfg_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= '0;
        else if (we) cfg <= decode_cfg(wdata);
    end
endmodule

// File: rtl/dc_trim_est.sv
module dc_trim_est
    import dc_trim_pkg::*;
#(
    parameter int DATA_W   = SAMPLE_W,
    parameter int FRAC_BITS = FRAC_W,
    parameter int K_WIDE   = 8,
    parameter int K_MED    = 12,
    parameter int K_NARROW = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              smp_valid,
    input  logic signed [DATA_W-1:0]          smp,
    input  trim_cfg_t                         cfg,
    output logic signed [DATA_W-1:0]          est_int,
    output logic signed [DATA_W+FRAC_BITS-1:0] est_full
);
    localparam int EST_W  = DATA_W + FRAC_BITS;
    localparam int DIFF_W = EST_W + 2;
    localparam int N_BW   = 3;
    localparam int K_TAB [N_BW] = '{K_WIDE, K_MED, K_NARROW};

    logic signed [EST_W-1:0]  est_q;
    logic signed [EST_W-1:0]  x_scaled;
    logic signed [DIFF_W-1:0] diff;
    logic signed [DIFF_W-1:0] step_c [N_BW];
    logic signed [DIFF_W-1:0] step_sel;
    logic signed [EST_W-1:0]  est_nxt;
    logic                     upd;

    assign x_scaled = {smp, {FRAC_BITS{1'b0}}};
    assign diff     = DIFF_W'(x_scaled) - DIFF_W'(est_q);

    for (genvar g = 0; g < N_BW; g++) begin : g_bw
        assign step_c[g] = diff >>> K_TAB[g];
    end

    always_comb begin
        case (cfg.mode)
            TRACK_MED:    step_sel = step_c[1];
            TRACK_NARROW: step_sel = step_c[2];
            default:      step_sel = step_c[0];
        endcase
    end

    assign est_nxt = est_q + EST_W'(step_sel);
    assign upd     = smp_valid && (cfg.mode != HOST_FIXED);

    always_ff @(posedge clk) begin
        if (rst || cfg.dis) est_q <= '0;
        else if (upd)       est_q <= est_nxt;
    end

    assign est_int  = est_q[EST_W-1 -: DATA_W];
    assign est_full = est_q;
endmodule

// File: rtl/dc_trim_sub.sv
module dc_trim_sub
    import dc_trim_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W
) (
    input  logic signed [DATA_W-1:0] x,
    input  trim_cfg_t                cfg,
    input  logic signed [DATA_W-1:0] est_int,
    output logic signed [DATA_W-1:0] y
);
    localparam int WIDE_W = DATA_W + 1;
    localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] off;
    logic signed [WIDE_W-1:0] wide;

    always_comb begin
        if (cfg.mode == HOST_FIXED) off = cfg.ofs;
        else if (cfg.dis)           off = '0;
        else                        off = est_int;
    end

    assign wide = WIDE_W'(x) - WIDE_W'(off);

    always_comb begin
        if (wide[WIDE_W-1] != wide[WIDE_W-2])
            y = wide[WIDE_W-1] ? NEG_LIM : POS_LIM;
        else
            y = wide[DATA_W-1:0];
    end
endmodule

// File: rtl/dc_trim.sv
module dc_trim
    import dc_trim_pkg::*;
#(
    parameter int DATA_W   = SAMPLE_W,
    parameter int FRAC_BITS = FRAC_W,
    parameter int K_WIDE   = 8,
    parameter int K_MED    = 12,
    parameter int K_NARROW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample
);
    localparam int EST_W = DATA_W + FRAC_BITS;

    trim_cfg_t                cfg_q;
    logic signed [DATA_W-1:0] est_int;
    logic signed [EST_W-1:0]  est_full;
    logic signed [DATA_W-1:0] y;
    logic                     cfg_dis;
    logic                     host_mode;

    assign cfg_dis   = cfg_q.dis;
    assign host_mode = (cfg_q.mode == HOST_FIXED);

    dc_trim_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg(cfg_q)
    );

    dc_trim_est #(
        .DATA_W(DATA_W), .FRAC_BITS(FRAC_BITS),
        .K_WIDE(K_WIDE), .K_MED(K_MED), .K_NARROW(K_NARROW)
    ) u_est (
        .clk(clk), .rst(rst), .smp_valid(in_valid), .smp(in_sample),
        .cfg(cfg_q), .est_int(est_int), .est_full(est_full)
    );

    dc_trim_sub #(.DATA_W(DATA_W)) u_sub (
        .x(in_sample), .cfg(cfg_q), .est_int(est_int), .y(y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_sample <= y;
        end
    end
endmodule

// File: rtl/dc_trim_chk.sv
module dc_trim_chk #(
    parameter int DATA_W = 16,
    parameter int EST_W  = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_sample,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_sample,
    input logic              cfg_dis,
    input logic              host_mode,
    input logic [EST_W-1:0]  est_full
);
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (!out_valid && est_full == '0));

    a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r6_estimate_held: assert property (@(posedge clk) disable iff (rst)
        (host_mode && !cfg_dis) |=> $stable(est_full));

    a_r7_estimate_cleared: assert property (@(posedge clk) disable iff (rst)
        cfg_dis |=> (est_full == '0));

    a_r7_pass_through: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cfg_dis && !host_mode) |=> (out_sample == $past(in_sample)));
endmodule

bind dc_trim dc_trim_chk #(.DATA_W(DATA_W), .EST_W(DATA_W + FRAC_BITS)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
    .out_valid(out_valid), .out_sample(out_sample), .cfg_dis(cfg_dis),
    .host_mode(host_mode), .est_full(est_full)
);

// File: tb/dc_trim_bench.sv
module dc_trim_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    always #2 clk = ~clk;

    dc_trim u_dc_trim (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    typedef struct {
        int    exp;
        string tag;
    } item_t;

    item_t  sb_q[$];
    int     n_cmp = 0;
    int     n_bad = 0;
    bit     finished = 0;

    // model state
    longint m_est = 0;
    bit     m_dis = 0;
    int     m_mode = 0;
    int     m_ofs = 0;

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(posedge clk); #1;
        in_valid  = 1'b0;
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
        m_dis  = w[18];
        m_mode = int'(w[17:16]);
        m_ofs  = int'($signed(w[15:0]));
        if (m_dis) m_est = 0;
    endtask

    task automatic send(input int x, input string tag);
        item_t  it;
        int     off;
        longint k;
        @(posedge clk); #1;
        in_valid  = 1'b1;
        in_sample = 16'(x);
        if (m_mode == 3)  off = m_ofs;
        else if (m_dis)   off = 0;
        else              off = int'(m_est >>> 16);
        it.exp = sat16(x - off);
        it.tag = tag;
        sb_q.push_back(it);
        if (!m_dis && m_mode != 3) begin
            k = (m_mode == 0) ? 8 : (m_mode == 1) ? 12 : 16;
            m_est = m_est + (((longint'(x) * 65536) - m_est) >>> k);
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    function automatic logic [31:0] cw(input bit dis, input int mode, input int ofs);
        return {13'b0, dis, 2'(mode), 16'(ofs)};
    endfunction

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                if (sb_q.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R2: actual out_valid 1 expected 0 (no sample pending)");
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, int'($signed(out_sample)), it.exp);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 out_sample", int'(out_sample), 0);

        // R1 / R3: default config, widest bandwidth tracking
        for (int i = 0; i < 40; i++) send(1000, "R3 widest");
        send(-200, "R3 step");
        idle(3);
        for (int i = 0; i < 5; i++) send(3000 + i * 7, "R3 ramp");
        idle(2);

        // R4: medium bandwidth
        write_cfg(cw(0, 1, 0));
        for (int i = 0; i < 30; i++) send(-3000, "R4 medium");

        // R5: narrowest bandwidth
        write_cfg(cw(0, 2, 0));
        for (int i = 0; i < 30; i++) send(20000, "R5 narrow");

        // R6: host offset, estimate held, then tracking resumes
        write_cfg(cw(0, 3, 16'h0123));
        send(0, "R6 host");
        send(1000, "R6 host");
        send(-1000, "R6 host");
        write_cfg(cw(0, 0, 0));
        for (int i = 0; i < 5; i++) send(500, "R6 resume");

        // R7: disable passes through and clears estimate
        write_cfg(cw(1, 0, 0));
        send(1234, "R7 pass");
        send(-32768, "R7 pass");
        send(32767, "R7 pass");
        write_cfg(cw(0, 0, 0));
        send(777, "R7 cleared");
        send(777, "R7 cleared");

        // R8: disabled with host mode still subtracts
        write_cfg(cw(1, 3, -5));
        send(100, "R8 dis host");
        send(-100, "R8 dis host");

        // R9: saturation at both ends
        write_cfg(cw(0, 3, 16'h8000));
        send(32767, "R9 sat high");
        send(-1, "R9 sat high");
        write_cfg(cw(0, 3, 1));
        send(-32768, "R9 sat low");
        write_cfg(cw(0, 3, -32767));
        send(1, "R9 sat high edge");

        // R10: reserved bits set, behaviour unchanged
        write_cfg(32'hFFF8_0000 | cw(0, 3, 100));
        send(250, "R10 reserved");
        send(-250, "R10 reserved");
        write_cfg(32'hFFF8_0000 | cw(0, 0, 0));
        for (int i = 0; i < 4; i++) send(60, "R10 reserved track");
        idle(4);

        check("R2 all results delivered", sb_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule